// File: doc/BRIEF.md
# AC-link Output Frame Command Encoder

This block is the controller end of a serial codec link. Once per 256-bit frame it assembles the outgoing tag word, command word and data word. The tag word holds a frame-valid flag, one valid tag for each of the twelve data slots, and a 2-bit target codec selector. The block also fills the audio slots and the GPIO slot. It then shifts the frame out MSB first on `sdo_o`, one bit per clock. `sync_o` is high during the 16 tag bits. The clock of the block is the link bit clock.

A requester presents one register access at a time: read or write, a 7-bit word-aligned index, 16-bit write data and a codec number from 0 to 3. The block takes the access only at a frame boundary, and only when no earlier access is in flight. `busy_o` stays high until the write frame has left the block, or until the read result has been captured from the next incoming frame. On a read, the block takes the register contents from the data slot of the incoming frame that follows. It returns them on `rd_data_o` with a one-cycle `rd_valid_o` pulse.

Top module: `aclink_frame_enc`

## Requirements
- R1: A frame is 256 bit periods: a 16-bit tag word followed by twelve 20-bit slots, each sent MSB first. `sync_o` is 1 for bit positions 0 to 15 of every frame and 0 for positions 16 to 255. Bit position 0 is the first period after reset release.
- R2: Tag bit 15 (frame valid) is 1 exactly when at least one of tag bits 14..3 is set or the codec selector is nonzero. A frame with nothing pending is all zeros.
- R3: Tag bit 15-s is the valid tag of slot s, for s from 1 to 12. Tag bit 2 is always 0. For audio slots 3..11, `play_valid_i[s-3]` sets the tag and sends `play_data_i[(s-3)*20 +: 20]` in slot s. When that flag is clear, the slot carries zeros.
- R4: A write to codec 0 sets tag bits 14 and 13 and leaves tag bits 1:0 at 00. Slot 1 bit 19 is 0 and slot 1 bits 18:12 hold the index with bit 12 forced to 0. Slot 2 is {write data, 4'b0000}. All of this goes in the same frame.
- R5: A read of codec 0 sets tag bit 14 only. Slot 1 bit 19 is 1 and slot 1 holds the index as in R4. Slot 2 is zero.
- R6: An access to codec 1, 2 or 3 places the codec number in tag bits 1:0 and leaves tag bits 14 and 13 clear. Slots 1 and 2 are laid out as in R4 and R5.
- R7: In every frame that carries no register access, tag bits 1:0 are 00 and slots 1 and 2 are zero.
- R8: Tag bit 3 is set, and slot 12 carries `gpio_data_i`, only when `gpio_valid_i` is set. Otherwise both are zero.
- R9: The request inputs are sampled only in the last bit period of a frame, and they go into the next frame. `busy_o` rises at bit 0 of that frame. A request that is sampled while `busy_o` is high is not carried: its frame has no register access.
- R10: After a write, `busy_o` falls at bit 0 of the frame that follows the write frame. Its `rd_valid_o` never pulses.
- R11: After a read, bits 19:4 of slot 2 of the next incoming frame on `sdi_i` appear on `rd_data_o`. They come with a one-cycle `rd_valid_o` pulse at bit position 56 of that frame, and `busy_o` falls in the same cycle.
- R12: During reset, `sdo_o`, `busy_o` and `rd_valid_o` are 0 and `sync_o` is 1. The first frame after reset is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access requested |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_idx_i | input | 7 | Register index (bit 0 ignored) |
| req_wdata_i | input | 16 | Write data |
| req_codec_i | input | 2 | Target codec, 0 = primary |
| play_valid_i | input | 9 | Valid flags for audio slots 3..11 |
| play_data_i | input | 180 | Audio slot words, slot 3 in the low 20 bits |
| gpio_valid_i | input | 1 | GPIO write pending |
| gpio_data_i | input | 20 | GPIO slot word |
| sdi_i | input | 1 | Serial data from the codec |
| sync_o | output | 1 | Frame sync, high during the tag word |
| sdo_o | output | 1 | Serial data to the codec |
| busy_o | output | 1 | Register access in flight |
| rd_valid_o | output | 1 | Read result strobe |
| rd_data_o | output | 16 | Read result |

## Verification
The bench offers requests while an earlier access is still in flight. A design that took such a request early would put a second command into a frame, and the frame compare would show it. Accesses to secondary codecs are mixed with accesses to the primary codec. A design that set the slot tags for a secondary access, or left the selector nonzero in an idle frame, would send wrong tag words. Audio and GPIO data stay nonzero while their flags are clear, and indexes with bit 0 set are used, so a missing zero substitution or RI0 mask shows in the serial stream. The codec model drives nonzero junk in slot 2 of every frame that is not a read-back frame. A capture in the wrong frame, at the wrong bit or after a write would then report wrong data or a stray strobe.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int unsigned SLOT_W  = 20;
  localparam int unsigned TAG_W   = 16;
  localparam int unsigned N_SLOTS = 12;
  localparam int unsigned IDX_W   = 7;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned CODEC_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND_WR,
    ST_SEND_RD,
    ST_WAIT_RB
  } acc_state_e;
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned SYNC_BITS  = 16,
  parameter int unsigned CNT_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic             last_bit_o,
  output logic             sync_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_BITS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST_CNT) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign bit_cnt_o  = cnt_q;
  assign last_bit_o = (cnt_q == LAST_CNT);
  assign sync_o     = (cnt_q < SYNC_END);

  // R1: frame wraps to position 0 after the last bit
  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_bit_o |=> (bit_cnt_o == '0));

  // R1: sync only starts at the frame start
  p_sync_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> (bit_cnt_o == '0));
endmodule

// File: rtl/aclink_slot_builder.sv
module aclink_slot_builder #(
  parameter int unsigned SLOT_W     = 20,
  parameter int unsigned TAG_W      = 16,
  parameter int unsigned N_SLOTS    = 12,
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CODEC_W    = 2,
  parameter int unsigned N_PLAY     = N_SLOTS - 3,
  parameter int unsigned FRAME_BITS = TAG_W + N_SLOTS * SLOT_W
) (
  input  logic                     acc_i,
  input  logic                     rd_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [CODEC_W-1:0]       codec_i,
  input  logic [N_PLAY-1:0]        play_valid_i,
  input  logic [N_PLAY*SLOT_W-1:0] play_data_i,
  input  logic                     gpio_valid_i,
  input  logic [SLOT_W-1:0]        gpio_data_i,
  output logic [FRAME_BITS-1:0]    frame_o
);
  // slot index 0 carries slot 1 (command), 1 carries slot 2 (data)
  localparam int unsigned AUD0    = 2;
  localparam int unsigned GPIO_SL = N_SLOTS - 1;
  localparam logic [IDX_W-1:0] IDX_MASK = ~IDX_W'(1);

  logic [N_SLOTS-1:0]   tag;
  logic [SLOT_W-1:0]    slot_w [N_SLOTS];
  logic [CODEC_W-1:0]   scra;
  logic [TAG_W-1:0]     slot0;
  logic                 prim;

  always_comb begin
    tag  = '0;
    for (int s = 0; s < N_SLOTS; s++) slot_w[s] = '0;
    prim = acc_i && (codec_i == '0);
    scra = acc_i ? codec_i : '0;
    // primary codec: slot tags mark the access; secondary: selector does
    tag[0] = prim;
    tag[1] = prim && !rd_i;
    if (acc_i) begin
      slot_w[0][SLOT_W-1]           = rd_i;
      slot_w[0][SLOT_W-2 -: IDX_W]  = idx_i & IDX_MASK;
      if (!rd_i) slot_w[1][SLOT_W-1 -: DATA_W] = wdata_i;
    end
    for (int k = 0; k < N_PLAY; k++) begin
      tag[AUD0+k] = play_valid_i[k];
      if (play_valid_i[k]) slot_w[AUD0+k] = play_data_i[k*SLOT_W +: SLOT_W];
    end
    tag[GPIO_SL] = gpio_valid_i;
    if (gpio_valid_i) slot_w[GPIO_SL] = gpio_data_i;

    slot0 = '0;
    slot0[TAG_W-1] = (|tag) || (|scra);
    for (int s = 0; s < N_SLOTS; s++) slot0[TAG_W-2-s] = tag[s];
    slot0[CODEC_W-1:0] = scra;
  end

  assign frame_o[FRAME_BITS-1 -: TAG_W] = slot0;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_pack
    assign frame_o[FRAME_BITS-TAG_W-1-s*SLOT_W -: SLOT_W] = slot_w[s];
  end
endmodule

// File: rtl/aclink_readback.sv
module aclink_readback #(
  parameter int unsigned SLOT_W  = 20,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned CAP_BIT = 55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdi_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic              arm_i,
  output logic              cap_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [CNT_W-1:0] CAP_CNT = CNT_W'(CAP_BIT);

  logic [SLOT_W-2:0] sh_q;
  logic [SLOT_W-1:0] word;

  assign word  = {sh_q, sdi_i};
  assign cap_o = arm_i && (bit_cnt_i == CAP_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      sh_q       <= word[SLOT_W-2:0];
      rd_valid_o <= cap_o;
      if (cap_o) rd_data_o <= word[SLOT_W-1 -: DATA_W];
    end
  end

  // R11: one strobe per read; the controller must disarm after capture
  p_single_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
endmodule

// File: rtl/aclink_frame_enc.sv
module aclink_frame_enc
  import aclink_pkg::*;
#(
  parameter int unsigned P_SLOT_W  = SLOT_W,
  parameter int unsigned P_TAG_W   = TAG_W,
  parameter int unsigned P_N_SLOTS = N_SLOTS,
  parameter int unsigned P_IDX_W   = IDX_W,
  parameter int unsigned P_DATA_W  = DATA_W,
  parameter int unsigned P_CODEC_W = CODEC_W
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                req_i,
  input  logic                                req_rd_i,
  input  logic [P_IDX_W-1:0]                  req_idx_i,
  input  logic [P_DATA_W-1:0]                 req_wdata_i,
  input  logic [P_CODEC_W-1:0]                req_codec_i,
  input  logic [P_N_SLOTS-4:0]                play_valid_i,
  input  logic [(P_N_SLOTS-3)*P_SLOT_W-1:0]   play_data_i,
  input  logic                                gpio_valid_i,
  input  logic [P_SLOT_W-1:0]                 gpio_data_i,
  input  logic                                sdi_i,
  output logic                                sync_o,
  output logic                                sdo_o,
  output logic                                busy_o,
  output logic                                rd_valid_o,
  output logic [P_DATA_W-1:0]                 rd_data_o
);
  localparam int unsigned FRAME_BITS = P_TAG_W + P_N_SLOTS * P_SLOT_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS);
  localparam int unsigned N_PLAY     = P_N_SLOTS - 3;
  localparam int unsigned CAP_BIT    = P_TAG_W + 2 * P_SLOT_W - 1;
  localparam int unsigned FV_POS     = FRAME_BITS - 1;
  localparam int unsigned TAG1_POS   = FRAME_BITS - 2;
  localparam int unsigned TAG2_POS   = FRAME_BITS - 3;
  localparam int unsigned SCRA_LO    = FRAME_BITS - P_TAG_W;
  localparam int unsigned RI0_POS    = FRAME_BITS - P_TAG_W - 1 - P_IDX_W;

  logic [CNT_W-1:0]      bit_cnt;
  logic                  last_bit;
  logic                  acc;
  logic                  cap;
  logic [FRAME_BITS-1:0] frame_nxt;
  logic [FRAME_BITS-1:0] sh_q;
  acc_state_e            state_q, state_d;

  aclink_frame_timer #(
    .FRAME_BITS(FRAME_BITS),
    .SYNC_BITS (P_TAG_W),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_cnt_o (bit_cnt),
    .last_bit_o(last_bit),
    .sync_o    (sync_o)
  );

  // requests only enter at the frame boundary and never while busy
  assign acc = last_bit && req_i && (state_q == ST_IDLE);

  aclink_slot_builder #(
    .SLOT_W    (P_SLOT_W),
    .TAG_W     (P_TAG_W),
    .N_SLOTS   (P_N_SLOTS),
    .IDX_W     (P_IDX_W),
    .DATA_W    (P_DATA_W),
    .CODEC_W   (P_CODEC_W),
    .N_PLAY    (N_PLAY),
    .FRAME_BITS(FRAME_BITS)
  ) u_build (
    .acc_i       (acc),
    .rd_i        (req_rd_i),
    .idx_i       (req_idx_i),
    .wdata_i     (req_wdata_i),
    .codec_i     (req_codec_i),
    .play_valid_i(play_valid_i),
    .play_data_i (play_data_i),
    .gpio_valid_i(gpio_valid_i),
    .gpio_data_i (gpio_data_i),
    .frame_o     (frame_nxt)
  );

  aclink_readback #(
    .SLOT_W (P_SLOT_W),
    .DATA_W (P_DATA_W),
    .CNT_W  (CNT_W),
    .CAP_BIT(CAP_BIT)
  ) u_rb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sdi_i     (sdi_i),
    .bit_cnt_i (bit_cnt),
    .arm_i     (state_q == ST_WAIT_RB),
    .cap_o     (cap),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (acc) state_d = req_rd_i ? ST_SEND_RD : ST_SEND_WR;
      ST_SEND_WR: if (last_bit) state_d = ST_IDLE;
      ST_SEND_RD: if (last_bit) state_d = ST_WAIT_RB;
      ST_WAIT_RB: if (cap) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      if (last_bit) sh_q <= frame_nxt;
      else          sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign sdo_o  = sh_q[FV_POS];
  assign busy_o = (state_q != ST_IDLE);

  // R2: frame-valid agrees with the rest of the loaded tag word
  p_fv_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(last_bit) |-> (sh_q[FV_POS] == (|sh_q[FV_POS-1 -: P_TAG_W-1])));

  // R4: word-aligned index in every loaded frame
  p_ri0_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(last_bit) |-> !sh_q[RI0_POS]);

  // R7: selector cleared whenever no access enters the frame
  p_idle_scra_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_bit && !acc) |=> (sh_q[SCRA_LO +: P_CODEC_W] == '0));

  // R9: a frame loaded while busy carries no register access
  p_no_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_bit && busy_o) |=>
      (!sh_q[TAG1_POS] && !sh_q[TAG2_POS] && sh_q[SCRA_LO +: P_CODEC_W] == '0));

  // R10: a write stays busy for the whole frame that carries it
  p_wr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND_WR && !last_bit) |=> (state_q == ST_SEND_WR));

  // R11: read strobe only closes a read-back wait
  p_rb_origin_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ($past(state_q) == ST_WAIT_RB && state_q == ST_IDLE));
endmodule

// File: tb/aclink_frame_enc_tb_top.sv
module aclink_frame_enc_tb_top;
  localparam int FB = 256;
  localparam int NP = 9;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, req_rd_i = 1'b0;
  logic [6:0]  req_idx_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [1:0]  req_codec_i = '0;
  logic [NP-1:0]    play_valid_i = '0;
  logic [NP*20-1:0] play_data_i = '0;
  logic        gpio_valid_i = 1'b0;
  logic [19:0] gpio_data_i = '0;
  logic        sdi_i = 1'b0;
  logic        sync_o, sdo_o, busy_o, rd_valid_o;
  logic [15:0] rd_data_o;

  always #10 clk = ~clk;

  aclink_frame_enc dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_rd_i(req_rd_i),
    .req_idx_i(req_idx_i), .req_wdata_i(req_wdata_i), .req_codec_i(req_codec_i),
    .play_valid_i(play_valid_i), .play_data_i(play_data_i),
    .gpio_valid_i(gpio_valid_i), .gpio_data_i(gpio_data_i), .sdi_i(sdi_i),
    .sync_o(sync_o), .sdo_o(sdo_o), .busy_o(busy_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  int checks = 0, errors = 0;
  int bc = 0, fn = 0;

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) begin bc <= 0; fn <= 0; end
    else if (bc == FB-1) begin bc <= 0; fn <= fn + 1; end
    else bc <= bc + 1;

  typedef struct { int f; logic [FB-1:0] frm; string tag; } exp_frm_t;
  typedef struct { int f; logic [15:0] data; } exp_rb_t;
  exp_frm_t fq[$];
  exp_rb_t  rq[$];
  logic [6:0]  rb_idx[int];
  logic [15:0] rb_dat[int];
  logic        bexp[int];
  int free_f = 1;
  int last_rd_f = -10;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [FB-1:0] act, input logic [FB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [19:0] pdat(int f, int k);
    return 20'h30000 | 20'(k << 12) | 20'(f & 12'hfff);
  endfunction

  function automatic logic [19:0] gdat(int f);
    return 20'hA0000 | 20'(f);
  endfunction

  function automatic logic [FB-1:0] exp_frame(bit acc, bit rd, logic [6:0] idx,
      logic [15:0] wd, logic [1:0] cd, logic [NP-1:0] pv, bit gv, int f);
    logic [15:0] s0;
    logic [19:0] sl [1:12];
    logic [FB-1:0] r;
    s0 = '0;
    for (int s = 1; s <= 12; s++) sl[s] = '0;
    if (acc) begin
      s0[1:0] = cd;
      if (cd == 2'd0) begin s0[14] = 1'b1; if (!rd) s0[13] = 1'b1; end
      sl[1] = {rd, idx[6:1], 1'b0, 12'h000};
      if (!rd) sl[2] = {wd, 4'h0};
    end
    for (int k = 0; k < NP; k++)
      if (pv[k]) begin s0[12-k] = 1'b1; sl[k+3] = pdat(f, k); end
    if (gv) begin s0[3] = 1'b1; sl[12] = gdat(f); end
    s0[15] = |s0[14:0];
    r[FB-1 -: 16] = s0;
    for (int s = 1; s <= 12; s++) r[FB-17-(s-1)*20 -: 20] = sl[s];
    return r;
  endfunction

  function automatic logic [FB-1:0] codec_frame(int f);
    logic [FB-1:0] r;
    r = '0;
    r[FB-1 -: 16] = 16'h9800 ^ 16'(f);
    if (rb_idx.exists(f)) begin
      r[FB-17 -: 20] = {1'b0, rb_idx[f], 12'h000};
      r[FB-37 -: 20] = {rb_dat[f], 4'h0};
    end else begin
      r[FB-17 -: 20] = 20'h5A5A5;
      r[FB-37 -: 20] = 20'hDEAD0 ^ 20'(f);
    end
    return r;
  endfunction

  // codec model: bit bc held for the cycle the design samples it
  always @(negedge clk) begin
    logic [FB-1:0] cf;
    cf = codec_frame(fn);
    sdi_i = cf[FB-1-bc];
  end

  // monitor: assembles the serial frame and compares with the scoreboard
  logic [FB-1:0] got = '0;
  always @(negedge clk) if (rst_ni) begin
    got[FB-1-bc] = sdo_o;
    if (bc == 0 || bc == 15) chk(sync_o == 1'b1, "R1", "sync high", FB'(sync_o), FB'(1));
    if (bc == 16 || bc == 255) chk(sync_o == 1'b0, "R1", "sync low", FB'(sync_o), FB'(0));
    if (bc == 10 && bexp.exists(fn))
      chk(busy_o == bexp[fn], bexp[fn] ? "R9" : "R10", "busy", FB'(busy_o), FB'(bexp[fn]));
    if (bc == FB-1) begin
      if (fn == 0) chk(got == '0, "R12", "first frame", got, '0);
      else if (fq.size() != 0 && fq[0].f == fn) begin
        exp_frm_t e;
        e = fq.pop_front();
        chk(got == e.frm, e.tag, "frame", got, e.frm);
      end
    end
    if (rd_valid_o) begin
      if (rq.size() == 0) chk(1'b0, "R11", "stray rd_valid", FB'(fn), '0);
      else begin
        exp_rb_t e;
        e = rq.pop_front();
        chk(e.f == fn && bc == 56, "R11", "strobe position", FB'(fn*1000+bc), FB'(e.f*1000+56));
        chk(rd_data_o == e.data, "R11", "read data", FB'(rd_data_o), FB'(e.data));
        chk(busy_o == 1'b0, "R11", "busy cleared", FB'(busy_o), '0);
      end
    end
  end

  task automatic drive(input int f, input bit rq_en, input bit rd, input logic [6:0] idx,
                       input logic [15:0] wd, input logic [1:0] cd,
                       input logic [NP-1:0] pv, input bit gv, input string tag);
    bit acc;
    do @(negedge clk); while (!(fn == f-1 && bc == 128));
    req_i = rq_en; req_rd_i = rd; req_idx_i = idx; req_wdata_i = wd; req_codec_i = cd;
    play_valid_i = pv; gpio_valid_i = gv; gpio_data_i = gdat(f);
    for (int k = 0; k < NP; k++) play_data_i[k*20 +: 20] = pdat(f, k);
    acc = rq_en && (f >= free_f);
    fq.push_back('{f, exp_frame(acc, rd, idx, wd, cd, pv, gv, f), tag});
    bexp[f] = acc || (last_rd_f == f-1);
    if (acc) begin
      free_f = f + 2;
      if (rd) begin
        logic [15:0] d;
        d = 16'hC0DE ^ 16'(f * 291);
        last_rd_f = f;
        rb_idx[f+1] = {idx[6:1], 1'b0};
        rb_dat[f+1] = d;
        rq.push_back('{f+1, d});
      end
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(sdo_o == 1'b0 && busy_o == 1'b0 && rd_valid_o == 1'b0 && sync_o == 1'b1,
            "R12", "reset outputs", FB'({sdo_o, busy_o, rd_valid_o, sync_o}), FB'(4'b0001));
        rst_ni = 1'b1;
        drive(1,  0, 0, 7'h00, 16'h0000, 2'd0, 9'h000, 0, "R2");
        drive(2,  1, 0, 7'h2B, 16'hBEEF, 2'd0, 9'h000, 0, "R4");
        drive(3,  1, 1, 7'h11, 16'h0000, 2'd0, 9'h005, 0, "R9");
        drive(4,  1, 1, 7'h26, 16'h7777, 2'd0, 9'h000, 0, "R5");
        drive(5,  1, 0, 7'h40, 16'h1111, 2'd3, 9'h000, 1, "R8");
        drive(6,  1, 0, 7'h7D, 16'h5A5A, 2'd2, 9'h1F0, 0, "R6");
        drive(7,  0, 0, 7'h00, 16'h0000, 2'd0, 9'h1FF, 1, "R3");
        drive(8,  1, 1, 7'h10, 16'h0000, 2'd3, 9'h000, 0, "R6");
        drive(9,  1, 0, 7'h33, 16'h2222, 2'd1, 9'h000, 0, "R9");
        drive(10, 1, 1, 7'h00, 16'h0000, 2'd0, 9'h0A0, 0, "R5");
        drive(11, 0, 0, 7'h00, 16'h0000, 2'd0, 9'h000, 0, "R7");
        drive(12, 1, 0, 7'h55, 16'h0001, 2'd1, 9'h000, 1, "R6");
        drive(13, 0, 0, 7'h00, 16'h0000, 2'd0, 9'h000, 0, "R10");
        drive(14, 0, 0, 7'h00, 16'h0000, 2'd0, 9'h000, 0, "R7");
        do @(negedge clk); while (fn != 15 || bc != 100);
        chk(rq.size() == 0, "R11", "pending read results", FB'(rq.size()), '0);
        chk(fq.size() == 0, "R1", "pending frames", FB'(fq.size()), '0);
      end
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", '0, '0);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule